// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Matcher

This block sits beside one local interrupt controller and decides, for each interprocessor interrupt message seen on a shared bus, whether that controller is a target. It takes the message's addressing fields and the sender's ID, together with the controller's own configuration: its physical ID, its logical ID, the logical format (flat or cluster) and a legacy option that narrows physical IDs to four bits.

A nonzero shorthand overrides the destination field. Without a shorthand, physical addressing compares the destination with the local ID, and an all-ones value reaches every unit. Logical addressing matches the destination against the logical ID in flat or cluster form.

A message with lowest-priority delivery does not set accept. When its address matches, it raises a candidate flag for an arbiter outside this block. Lowest-priority delivery aimed at a physical broadcast is an unsupported combination. It raises the illegal flag and produces neither accept nor candidate. All results are registered and appear one clock after the message strobe.

Top module: `ipi_dest_match`

## Requirements
- R1: While rst_n is low and on the first sample after reset, out_valid, accept, illegal and lp_candidate are all 0.
- R2: Outputs are registered. out_valid is 1 exactly one clock after a cycle with msg_valid high. In a clock after a cycle with msg_valid low, all four outputs are 0 whatever the other inputs are.
- R3: Physical addressing (dest_logical=0, shorthand=00, narrow_ids=0): a dest_field equal to local_id matches, 8'hFF matches every unit, and any other value does not match.
- R4: With narrow_ids=1, physical addressing compares only bits [3:0] of dest_field and local_id, and ignores the upper bits. A value of 4'hF in bits [3:0] is a broadcast.
- R5: Logical flat addressing (dest_logical=1, cluster_fmt=0) matches when dest_field AND logical_id is nonzero.
- R6: Logical cluster addressing (cluster_fmt=1) matches when bits [7:4] of dest_field equal bits [7:4] of logical_id, or when dest_field[7:4] is 4'hF. In either case, bits [3:0] of the two values must also share a set bit.
- R7: In logical addressing, a dest_field of 8'hFF matches in both formats, even when logical_id is 0.
- R8: A nonzero shorthand overrides dest_field and dest_logical. 2'b01 (self) matches only when sender_id equals local_id. 2'b10 (all) always matches. 2'b11 (all but self) matches only when the two IDs differ. With narrow_ids=1, only bits [3:0] of the IDs are compared.
- R9: When deliv_mode is 3'b001 (lowest priority), a match sets lp_candidate instead of accept. accept and lp_candidate are never both 1.
- R10: Lowest-priority delivery with shorthand 2'b00, dest_logical=0 and a physical broadcast destination (per R3/R4) sets illegal and clears accept and lp_candidate. Shorthand broadcasts never set illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message fields are valid this cycle |
| dest_logical | input | 1 | 1 = logical addressing, 0 = physical |
| dest_field | input | 8 | Destination field of the message |
| shorthand | input | 2 | 00 none, 01 self, 10 all, 11 all but self |
| deliv_mode | input | 3 | Delivery mode; 3'b001 is lowest priority |
| sender_id | input | 8 | Physical ID of the sending unit |
| local_id | input | 8 | Physical ID of this unit |
| logical_id | input | 8 | Logical ID of this unit |
| cluster_fmt | input | 1 | 1 = cluster logical format, 0 = flat |
| narrow_ids | input | 1 | 1 = four-bit physical IDs |
| out_valid | output | 1 | Results below are valid |
| accept | output | 1 | This unit takes the message |
| illegal | output | 1 | Unsupported mode combination seen |
| lp_candidate | output | 1 | Unit joins lowest-priority arbitration |

## Verification
The block holds no state beyond its output register, so a fault in the match logic shows one clock after the strobe. It appears as a wrong accept or candidate for one particular combination of addressing, format and shorthand. The vector table therefore pairs each matching case with a near miss that differs in one nibble or one ID bit. A stale output register would show as a nonzero flag in the clock after a quiet cycle, and a dedicated check looks for exactly that.

// File: rtl/ipi_dest_match.sv
module ipi_dest_match #(
  parameter int ID_W = 8,
  parameter logic [2:0] LOWPRI_CODE = 3'b001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msg_valid,
  input  logic            dest_logical,
  input  logic [ID_W-1:0] dest_field,
  input  logic [1:0]      shorthand,
  input  logic [2:0]      deliv_mode,
  input  logic [ID_W-1:0] sender_id,
  input  logic [ID_W-1:0] local_id,
  input  logic [ID_W-1:0] logical_id,
  input  logic            cluster_fmt,
  input  logic            narrow_ids,
  output logic            out_valid,
  output logic            accept,
  output logic            illegal,
  output logic            lp_candidate
);
  localparam int NIB = ID_W / 2;

  logic phys_bcast, phys_hit, log_hit, flat_hit, clus_hit, same_id;
  logic addr_hit, is_lp, bad_combo;

  assign phys_bcast = narrow_ids ? (&dest_field[NIB-1:0]) : (&dest_field);
  assign phys_hit   = phys_bcast |
                      (narrow_ids ? (dest_field[NIB-1:0] == local_id[NIB-1:0])
                                  : (dest_field == local_id));

  assign flat_hit = |(dest_field & logical_id);
  assign clus_hit = ((dest_field[ID_W-1:NIB] == logical_id[ID_W-1:NIB]) ||
                     (&dest_field[ID_W-1:NIB])) &&
                    (|(dest_field[NIB-1:0] & logical_id[NIB-1:0]));
  assign log_hit  = (&dest_field) | (cluster_fmt ? clus_hit : flat_hit);

  assign same_id = narrow_ids ? (sender_id[NIB-1:0] == local_id[NIB-1:0])
                              : (sender_id == local_id);

  always_comb begin
    case (shorthand)
      2'b01:   addr_hit = same_id;
      2'b10:   addr_hit = 1'b1;
      2'b11:   addr_hit = !same_id;
      default: addr_hit = dest_logical ? log_hit : phys_hit;
    endcase
  end

  assign is_lp     = (deliv_mode == LOWPRI_CODE);
  assign bad_combo = is_lp && (shorthand == 2'b00) && !dest_logical && phys_bcast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      accept       <= 1'b0;
      illegal      <= 1'b0;
      lp_candidate <= 1'b0;
    end else begin
      out_valid    <= msg_valid;
      accept       <= msg_valid && addr_hit && !is_lp;
      illegal      <= msg_valid && bad_combo;
      lp_candidate <= msg_valid && addr_hit && is_lp && !bad_combo;
    end
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> out_valid);

  // R2
  quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> !(out_valid || accept || illegal || lp_candidate));

  // R9
  acc_cand_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({accept, lp_candidate, illegal}) <= 1);

  // R8
  all_shorthand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && shorthand == 2'b10 && deliv_mode != LOWPRI_CODE) |=> accept);

  // R10
  illegal_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && deliv_mode == LOWPRI_CODE && shorthand == 2'b00 && !dest_logical
     && dest_field == {ID_W{1'b1}}) |=> (illegal && !accept && !lp_candidate));

  // R9
  lp_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && deliv_mode == LOWPRI_CODE) |=> !accept);
endmodule

// File: tb/ipi_dest_match_tb.sv
module ipi_dest_match_tb;
  localparam int PERIOD = 10;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_valid = 1'b0, dest_logical = 1'b0, cluster_fmt = 1'b0, narrow_ids = 1'b0;
  logic [7:0] dest_field = '0, sender_id = '0, local_id = '0, logical_id = '0;
  logic [1:0] shorthand = '0;
  logic [2:0] deliv_mode = '0;
  logic out_valid, accept, illegal, lp_candidate;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  ipi_dest_match u_dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .dest_logical(dest_logical),
    .dest_field(dest_field), .shorthand(shorthand), .deliv_mode(deliv_mode),
    .sender_id(sender_id), .local_id(local_id), .logical_id(logical_id),
    .cluster_fmt(cluster_fmt), .narrow_ids(narrow_ids), .out_valid(out_valid),
    .accept(accept), .illegal(illegal), .lp_candidate(lp_candidate));

  // {logical, dest, sh, dm, sender, local, ldr, cluster, narrow, exp_acc, exp_ill, exp_cand, req}
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 8'h12, 2'b00, 3'b000, 8'h05, 8'h12, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 exact
    {1'b0, 8'h13, 2'b00, 3'b000, 8'h05, 8'h12, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 miss
    {1'b0, 8'hFF, 2'b00, 3'b000, 8'h05, 8'h12, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 bcast
    {1'b0, 8'hA5, 2'b00, 3'b000, 8'h01, 8'h05, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 upper ignored
    {1'b0, 8'h0F, 2'b00, 3'b000, 8'h01, 8'h03, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 bcast
    {1'b0, 8'h06, 2'b00, 3'b000, 8'h01, 8'h05, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 miss
    {1'b1, 8'h30, 2'b00, 3'b000, 8'h01, 8'h05, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 hit
    {1'b1, 8'h0C, 2'b00, 3'b000, 8'h01, 8'h05, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 miss
    {1'b1, 8'h23, 2'b00, 3'b000, 8'h01, 8'h05, 8'h21, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 hit
    {1'b1, 8'h33, 2'b00, 3'b000, 8'h01, 8'h05, 8'h21, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 cluster miss
    {1'b1, 8'hF2, 2'b00, 3'b000, 8'h01, 8'h05, 8'h52, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 all clusters
    {1'b1, 8'h24, 2'b00, 3'b000, 8'h01, 8'h05, 8'h21, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 member miss
    {1'b1, 8'hFF, 2'b00, 3'b000, 8'h01, 8'h05, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 flat
    {1'b0, 8'h99, 2'b01, 3'b000, 8'h07, 8'h07, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 self
    {1'b0, 8'h07, 2'b01, 3'b000, 8'h08, 8'h07, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 self miss
    {1'b1, 8'h00, 2'b10, 3'b000, 8'h08, 8'h07, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 all
    {1'b0, 8'hFF, 2'b11, 3'b000, 8'h07, 8'h07, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 others, self
    {1'b0, 8'h00, 2'b11, 3'b000, 8'h08, 8'h07, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 others
    {1'b0, 8'h12, 2'b00, 3'b001, 8'h05, 8'h12, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 phys
    {1'b1, 8'h30, 2'b00, 3'b001, 8'h05, 8'h12, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 logical
    {1'b0, 8'hFF, 2'b00, 3'b001, 8'h05, 8'h12, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 bcast
    {1'b0, 8'h0F, 2'b00, 3'b001, 8'h05, 8'h02, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 narrow
    {1'b0, 8'h13, 2'b00, 3'b001, 8'h05, 8'h12, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 miss
    {1'b0, 8'h00, 2'b10, 3'b001, 8'h05, 8'h12, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10}  // R10 shorthand
  };

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {valid,acc,ill,cand} got=%b exp=%b", req, got, exp);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    check("R1", {out_valid, accept, illegal, lp_candidate}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first sample after reset
    check("R1", {out_valid, accept, illegal, lp_candidate}, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      {dest_logical, dest_field, shorthand, deliv_mode, sender_id, local_id,
       logical_id, cluster_fmt, narrow_ids} = v[46:7];
      msg_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", v[3:0], i),
            {out_valid, accept, illegal, lp_candidate}, {1'b1, v[6:4]});
    end

    // R2: matching inputs with no strobe give quiet outputs next clock
    msg_valid = 1'b0; dest_logical = 1'b0; shorthand = 2'b10; deliv_mode = 3'b000;
    @(negedge clk);
    check("R2 idle", {out_valid, accept, illegal, lp_candidate}, 4'b0000);
    // R2: strobe again, then drop it: one-cycle result only
    msg_valid = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
    check("R2 strobe", {out_valid, accept, illegal, lp_candidate}, 4'b1100);
    @(negedge clk);
    check("R2 drop", {out_valid, accept, illegal, lp_candidate}, 4'b0000);
    // R8 narrow self compares low nibble only
    msg_valid = 1'b1; narrow_ids = 1'b1; shorthand = 2'b01;
    sender_id = 8'h34; local_id = 8'hC4;
    @(negedge clk);
    check("R8 narrow self", {out_valid, accept, illegal, lp_candidate}, 4'b1100);
    // R1 reset clears a live result
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", {out_valid, accept, illegal, lp_candidate}, 4'b0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule